// File: doc/BRIEF.md
# Split Serial Access Register

This block holds a 512-word by 4-bit serial shift store, treated as two halves of 256 words each. A serial pointer walks through the store one word per serial clock. In output mode it presents the addressed word. In input mode it captures a word into the addressed location. While one half is being shifted, the other half can take a whole row from the memory array, or give a whole row back to it, through a parallel half-row port. The flag `qsf` reports which half the pointer is in.

A conventional read transfer (`xfer_cmd` = 00) loads the half named by the top bit of `tap_addr` and starts output mode at the tap. A pseudo write (01) moves no data. It switches to input mode and places the pointer at the tap. Split read (10) and split write (11) always act on the half the pointer is not in. For these two commands the top tap bit is ignored, and the half is chosen inside the block and driven on `row_half`. A split request is refused with a one-cycle `xfer_err` pulse in three cases: it comes within `GUARD_CYC` clocks after the flag changed, it does not match the current mode, or the block is still idle.

The controller has three states. `ST_IDLE` moves to `ST_SERIAL_OUT` on a read, or to `ST_SERIAL_IN` on a pseudo write. `ST_SERIAL_OUT` moves to `ST_SERIAL_IN` on a pseudo write. `ST_SERIAL_IN` moves to `ST_SERIAL_OUT` on a read. Every other request leaves the state unchanged.

Top module: `split_serial_reg`

## Requirements
- R1: After reset `qsf`, `sdata_oe`, `row_we` and `xfer_err` are all 0.
- R2: A read command (`xfer_cmd`=00) stores `row_in` (word i in bits i*4+3..i*4) into the half given by `tap_addr[8]`. It sets the pointer to `tap_addr`, and `sdata_oe` is 1 from the next cycle.
- R3: In output mode, each `sc_tick` cycle puts the word at the pointer on `sdata_out` after that clock edge and advances the pointer by one.
- R4: Advancing from the last word of one half goes to word 0 of the other half. The last word of the upper half wraps to word 0 of the lower half. `qsf` changes on the edge of that last tick and at no other time except a conventional command.
- R5: `qsf` equals the half the pointer is in (0 lower, 1 upper), including right after a read to an upper-half tap.
- R6: A split read (10) in output mode stores `row_in` into the inactive half. Serial output from the active half goes on unchanged.
- R7: For split commands `row_half` is the inactive half (the inverse of `qsf`) whatever `tap_addr[8]` holds. For conventional commands it is `tap_addr[8]`.
- R8: A pseudo write (01) sets the pointer to `tap_addr` and clears `sdata_oe` from the next cycle. It asserts no `row_we` and changes no stored word.
- R9: In input mode, each `sc_tick` cycle writes `sdata_in` to the word at the pointer and advances the pointer.
- R10: An accepted split write (11) in input mode raises `row_we` in the request cycle, with `row_out` holding the inactive half's words in the R2 packing.
- R11: A split request is refused with `xfer_err` high for exactly the next cycle, and without load or store, in three cases: it is made within `GUARD_CYC` clocks after a `qsf` change, a split read is made outside output mode, or a split write is made outside input mode.
- R12: `sc_tick` is ignored in a cycle where `xfer_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_req | input | 1 | Transfer request strobe |
| xfer_cmd | input | 2 | 00 read, 01 pseudo write, 10 split read, 11 split write |
| tap_addr | input | 9 | Start location; top bit ignored for split commands |
| row_in | input | 1024 | Half-row from the array |
| row_out | output | 1024 | Half-row toward the array |
| row_half | output | 1 | Half selected for the current transfer |
| row_we | output | 1 | Store strobe toward the array |
| sc_tick | input | 1 | Serial clock enable |
| sdata_in | input | 4 | Serial input word |
| sdata_out | output | 4 | Serial output word |
| sdata_oe | output | 1 | High in output mode |
| qsf | output | 1 | Active half flag |
| xfer_err | output | 1 | Refused split request pulse |

## Verification
A pointer that is off by one shows up as a wrong `sdata_out` word on the very next tick in output mode. In input mode the error stays hidden until the next split write puts the half on `row_out`. A wrong half decision appears at once on `row_half` in the request cycle. A flag that toggles late or early is visible on `qsf` at the wrap tick. A guard counter that is wrong shows as a missing or spurious `xfer_err` one cycle after the request.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;
    typedef enum logic [1:0] {
        CMD_READ      = 2'b00,
        CMD_PSEUDO_WR = 2'b01,
        CMD_SPLIT_RD  = 2'b10,
        CMD_SPLIT_WR  = 2'b11
    } ssr_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'b00,
        ST_SERIAL_OUT = 2'b01,
        ST_SERIAL_IN  = 2'b10
    } ssr_state_e;
endpackage

// File: rtl/ssr_ptr.sv
`timescale 1ns/1ps
module ssr_ptr #(
    parameter int AW        = 9,
    parameter int GUARD_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          qsf,
    output logic          guard_busy
);
    localparam int GW = (GUARD_CYC > 0) ? $clog2(GUARD_CYC + 1) : 1;

    logic wrap;
    assign wrap = step && (&ptr[AW-2:0]);

    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (load)  ptr <= load_addr;
        else if (step)  ptr <= ptr + 1'b1;
    end

    assign qsf = ptr[AW-1];

    AST_QSF_ON_SERIAL_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step) && !$past(load)) |-> $stable(qsf)); // R4

    generate
        if (GUARD_CYC > 0) begin : g_guard
            logic [GW-1:0] guard_cnt;
            always_ff @(posedge clk) begin
                if (!rst_n)              guard_cnt <= '0;
                else if (load)           guard_cnt <= '0;
                else if (wrap)           guard_cnt <= GW'(GUARD_CYC);
                else if (guard_cnt != 0) guard_cnt <= guard_cnt - 1'b1;
            end
            assign guard_busy = (guard_cnt != 0);

            AST_GUARD_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
                (wrap && !load) |=> guard_busy); // R11
        end else begin : g_noguard
            assign guard_busy = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ssr_store.sv
`timescale 1ns/1ps
module ssr_store #(
    parameter int HALF_WORDS = 256,
    parameter int WORD_W     = 4,
    parameter int AW         = 9,
    parameter int ROW_W      = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              load_half,
    input  logic [ROW_W-1:0]  row_in,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              dump_half,
    output logic [ROW_W-1:0]  row_out
);
    localparam int LW = AW - 1;

    logic [WORD_W-1:0] mem [2*HALF_WORDS];

    always_ff @(posedge clk) begin
        if (load_en) begin
            for (int i = 0; i < HALF_WORDS; i++) begin
                mem[{load_half, LW'(i)}] <= row_in[i*WORD_W +: WORD_W];
            end
        end
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    generate
        for (genvar g = 0; g < HALF_WORDS; g++) begin : g_row
            assign row_out[g*WORD_W +: WORD_W] = mem[{dump_half, LW'(g)}];
        end
    endgenerate

    AST_NO_HALF_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && wr_en) |-> (load_half != wr_addr[AW-1])); // R6
endmodule

// File: rtl/split_serial_reg.sv
`timescale 1ns/1ps
module split_serial_reg
    import ssr_pkg::*;
#(
    parameter int HALF_WORDS = 256,
    parameter int WORD_W     = 4,
    parameter int GUARD_CYC  = 4,
    localparam int AW        = $clog2(2 * HALF_WORDS),
    localparam int ROW_W     = HALF_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_req,
    input  logic [1:0]        xfer_cmd,
    input  logic [AW-1:0]     tap_addr,
    input  logic [ROW_W-1:0]  row_in,
    output logic [ROW_W-1:0]  row_out,
    output logic              row_half,
    output logic              row_we,
    input  logic              sc_tick,
    input  logic [WORD_W-1:0] sdata_in,
    output logic [WORD_W-1:0] sdata_out,
    output logic              sdata_oe,
    output logic              qsf,
    output logic              xfer_err
);
    ssr_state_e state, state_next;
    ssr_cmd_e   cmd;

    logic          conv, split_req, split_rd_ok, split_wr_ok, reject;
    logic          step, load_en, wr_en, guard_busy;
    logic [AW-1:0] ptr;
    logic [WORD_W-1:0] rd_data;

    assign cmd         = ssr_cmd_e'(xfer_cmd);
    assign conv        = xfer_req && !xfer_cmd[1];
    assign split_req   = xfer_req && xfer_cmd[1];
    assign split_rd_ok = split_req && (cmd == CMD_SPLIT_RD) && (state == ST_SERIAL_OUT) && !guard_busy;
    assign split_wr_ok = split_req && (cmd == CMD_SPLIT_WR) && (state == ST_SERIAL_IN)  && !guard_busy;
    assign reject      = split_req && !split_rd_ok && !split_wr_ok;
    assign step        = sc_tick && !xfer_req && (state != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_next;
    end

    // transitions
    always_comb begin
        state_next = state;
        unique case (state)
            ST_IDLE: begin
                if (conv) state_next = (cmd == CMD_READ) ? ST_SERIAL_OUT : ST_SERIAL_IN;
            end
            ST_SERIAL_OUT: begin
                if (conv && cmd == CMD_PSEUDO_WR) state_next = ST_SERIAL_IN;
            end
            ST_SERIAL_IN: begin
                if (conv && cmd == CMD_READ) state_next = ST_SERIAL_OUT;
            end
            default: state_next = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        row_half = conv ? tap_addr[AW-1] : ~qsf;
        row_we   = split_wr_ok;
        load_en  = (conv && cmd == CMD_READ) || split_rd_ok;
        wr_en    = step && (state == ST_SERIAL_IN);
        sdata_oe = (state == ST_SERIAL_OUT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata_out <= '0;
            xfer_err  <= 1'b0;
        end else begin
            xfer_err <= reject;
            if (step && state == ST_SERIAL_OUT) sdata_out <= rd_data;
        end
    end

    ssr_ptr #(.AW(AW), .GUARD_CYC(GUARD_CYC)) i_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (conv),
        .load_addr  (tap_addr),
        .step       (step),
        .ptr        (ptr),
        .qsf        (qsf),
        .guard_busy (guard_busy)
    );

    ssr_store #(.HALF_WORDS(HALF_WORDS), .WORD_W(WORD_W), .AW(AW), .ROW_W(ROW_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_half (row_half),
        .row_in    (row_in),
        .wr_en     (wr_en),
        .wr_addr   (ptr),
        .wr_data   (sdata_in),
        .rd_addr   (ptr),
        .rd_data   (rd_data),
        .dump_half (row_half),
        .row_out   (row_out)
    );

    AST_ERR_AFTER_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> $past(xfer_req && xfer_cmd[1])); // R11
    AST_WE_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        row_we |-> !sdata_oe); // R10
    AST_LOAD_OTHER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && xfer_cmd[1]) |-> (row_half != ptr[AW-1])); // R7
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sdata_oe && !row_we && !qsf)); // R1
endmodule

// File: tb/test_split_serial_reg.sv
`timescale 1ns/1ps
module test_split_serial_reg;
    localparam int HW = 8, WW = 4, GC = 3, AW = 4, RW = 32;

    logic clk = 0, rst_n = 0;
    logic xfer_req = 0, sc_tick = 0, sdata_oe, qsf, xfer_err, row_half, row_we;
    logic [1:0] xfer_cmd = 0;
    logic [AW-1:0] tap_addr = 0;
    logic [RW-1:0] row_in = 0, row_out;
    logic [WW-1:0] sdata_in = 0, sdata_out;

    int checks = 0, errors = 0;
    logic [3:0] bm [16];
    logic [3:0] bptr = 0;
    logic bout = 0;
    logic [3:0] exp_q [$];
    logic s_half, s_we;
    logic [RW-1:0] s_row;
    bit done = 0;

    always #2.5 clk = ~clk;

    split_serial_reg #(.HALF_WORDS(HW), .WORD_W(WW), .GUARD_CYC(GC)) i_split_serial_reg (
        .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_cmd(xfer_cmd),
        .tap_addr(tap_addr), .row_in(row_in), .row_out(row_out), .row_half(row_half),
        .row_we(row_we), .sc_tick(sc_tick), .sdata_in(sdata_in), .sdata_out(sdata_out),
        .sdata_oe(sdata_oe), .qsf(qsf), .xfer_err(xfer_err));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares serial output against scoreboard
    always @(posedge clk) begin
        if (sc_tick && !xfer_req && bout) begin
            #1;
            if (exp_q.size() == 0) chk("R3 unexpected word", 64'(sdata_out), 64'hdead);
            else chk("R3 serial word", 64'(sdata_out), 64'(exp_q.pop_front()));
        end
    end

    function automatic logic [RW-1:0] mkrow(input logic [3:0] seed);
        logic [RW-1:0] r;
        for (int i = 0; i < HW; i++) r[i*4 +: 4] = 4'(seed + 3*i);
        return r;
    endfunction

    function automatic void mload(input logic h, input logic [RW-1:0] r);
        for (int i = 0; i < HW; i++) bm[{h, 3'(i)}] = r[i*4 +: 4];
    endfunction

    function automatic logic [RW-1:0] mrow(input logic h);
        logic [RW-1:0] r;
        for (int i = 0; i < HW; i++) r[i*4 +: 4] = bm[{h, 3'(i)}];
        return r;
    endfunction

    task automatic drive_cmd(input logic [1:0] c, input logic [3:0] tap,
                             input logic [RW-1:0] row, input logic tk);
        xfer_req = 1; xfer_cmd = c; tap_addr = tap; row_in = row; sc_tick = tk;
        #1;
        s_half = row_half; s_we = row_we; s_row = row_out;
        @(negedge clk);
        xfer_req = 0; sc_tick = 0;
    endtask

    task automatic tick(input logic [3:0] d);
        sc_tick = 1; sdata_in = d;
        if (bout) exp_q.push_back(bm[bptr]);
        else bm[bptr] = d;
        bptr = bptr + 1'b1;
        @(negedge clk);
        sc_tick = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] ra, rb, rc, re;
        ra = mkrow(4'h1); rb = mkrow(4'h8); rc = mkrow(4'h3); re = mkrow(4'hC);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 qsf", 64'(qsf), 0); chk("R1 oe", 64'(sdata_oe), 0);
        chk("R1 err", 64'(xfer_err), 0); chk("R1 row_we", 64'(row_we), 0);

        // R2 conventional read into lower half
        drive_cmd(2'b00, 4'd0, ra, 0);
        mload(0, ra); bptr = 0; bout = 1;
        chk("R2 row_half", 64'(s_half), 0);
        chk("R2 oe", 64'(sdata_oe), 1); chk("R5 qsf low", 64'(qsf), 0);
        for (int k = 0; k < 5; k++) tick(4'h0);

        // R12 tick ignored during command; R7 top tap bit ignored; R6 split read
        drive_cmd(2'b10, 4'b0010, rb, 1);
        mload(1, rb);
        chk("R7 split half", 64'(s_half), 1);
        chk("R6 no err", 64'(xfer_err), 0);
        tick(0); tick(0);
        chk("R4 qsf before last", 64'(qsf), 0);
        tick(0);
        chk("R4 qsf at wrap", 64'(qsf), 1);

        // R11 guard window refusal
        drive_cmd(2'b10, 4'd0, rc, 0);
        chk("R11 guard err", 64'(xfer_err), 1);
        idle(1);
        chk("R11 err pulse", 64'(xfer_err), 0);
        idle(GC);
        drive_cmd(2'b10, 4'b1000, rc, 0);
        mload(0, rc);
        chk("R7 split half low", 64'(s_half), 0);
        chk("R6 accepted", 64'(xfer_err), 0);
        for (int k = 0; k < 8; k++) tick(0);
        chk("R4 wrap to low", 64'(qsf), 0);
        tick(0);

        // R8 pseudo write
        drive_cmd(2'b01, 4'd3, '0, 0);
        bout = 0; bptr = 3;
        chk("R8 no row_we", 64'(s_we), 0);
        chk("R8 oe off", 64'(sdata_oe), 0);
        for (int k = 0; k < 5; k++) tick(4'(9 + k));
        chk("R4 qsf input wrap", 64'(qsf), 1);
        drive_cmd(2'b11, 4'd0, '0, 0);
        chk("R11 guard no we", 64'(s_we), 0);
        chk("R11 guard err wr", 64'(xfer_err), 1);
        idle(GC + 1);
        drive_cmd(2'b11, 4'd0, '0, 0);
        chk("R10 row_we", 64'(s_we), 1);
        chk("R10 row_half", 64'(s_half), 0);
        chk("R9 R10 row_out", 64'(s_row), 64'(mrow(0)));
        drive_cmd(2'b10, 4'd0, re, 0);
        chk("R11 mode err", 64'(xfer_err), 1);
        tick(4'h5); tick(4'h6);

        // R5 read to upper tap
        drive_cmd(2'b00, 4'd12, re, 0);
        mload(1, re); bptr = 12; bout = 1;
        chk("R5 qsf high", 64'(qsf), 1);
        chk("R2 oe on", 64'(sdata_oe), 1);
        for (int k = 0; k < 4; k++) tick(0);
        chk("R4 upper wrap", 64'(qsf), 0);
        tick(0);
        idle(1);
        chk("R3 queue drained", 64'(exp_q.size()), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule